// File: doc/BRIEF.md
# Block floating-point stage scaler

This block sits beside a fixed-point FFT engine and keeps its data inside the word width from one stage to the next. While a stage runs, every butterfly result (real and imaginary part) is shown to the block with a valid strobe. The block looks at the three most significant bits of each part and sorts the word into one of three growth classes. The classes are no growth, one bit of growth and two bits of growth. Over the stage it keeps the largest class it has seen.

When the engine signals the end of a stage, the block turns that worst-case class into a right-shift amount of 0, 1 or 2. It presents the amount and adds it to a block exponent for the frame. It then starts the next stage from the no-growth class. The engine reads the stage's words back as operands for the next stage and passes them through the block's shift path. That path applies the current amount as a sign-keeping arithmetic right shift and returns a narrower word. A frame-start pulse clears the exponent, so each transform carries its own scale factor.

Top module: `bfp_stage_scaler`

## Requirements
- R1: A valid result part whose three top bits are 000 or 111 is class 0 (needs a shift of 0).
- R2: A valid result part whose three top bits are 001 or 110 is class 1 (needs a shift of 1).
- R3: A valid result part whose three top bits are 010, 011, 100 or 101 is class 2 (needs a shift of 2).
- R4: The stage shift is the largest class over the real and imaginary parts of every word with `res_valid` high in the stage. Parts presented with `res_valid` low have no effect.
- R5: A `stage_end` pulse with `frame_start` low raises `shift_valid` for exactly one cycle on the next cycle. In that cycle `shift_out` carries the stage shift. A valid word in the `stage_end` cycle counts toward the ending stage. The next stage then starts from class 0. `shift_out` holds its value until the next stage end and never reads 3.
- R6: On the same edge that updates `shift_out`, `exp_out` becomes the previous exponent plus the new shift. The sum saturates at 2^EXP_W-1. At all other times `exp_out` holds its value.
- R7: `frame_start` clears `exp_out`, `shift_out` and the stage maximum on the next edge. A `stage_end` in the same cycle is ignored and produces no `shift_valid`.
- R8: One cycle after `in_valid`, `out_valid` is high. `out_re`/`out_im` are then the low 16 bits of the 18-bit inputs, arithmetically right-shifted by the `shift_out` value that was present when the inputs were sampled. `out_valid` is low one cycle after `in_valid` is low.
- R9: After reset, `shift_out`, `exp_out`, `shift_valid` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Start of a new transform; clears the exponent |
| res_valid | input | 1 | Butterfly result strobe |
| res_re | input | 18 | Result real part |
| res_im | input | 18 | Result imaginary part |
| stage_end | input | 1 | Last cycle of a stage |
| shift_out | output | 2 | Shift chosen at the last stage end |
| shift_valid | output | 1 | One-cycle pulse when a new shift is chosen |
| exp_out | output | 5 | Accumulated block exponent |
| in_valid | input | 1 | Operand strobe for the shift path |
| in_re | input | 18 | Operand real part |
| in_im | input | 18 | Operand imaginary part |
| out_valid | output | 1 | Scaled operand strobe |
| out_re | output | 16 | Scaled real part |
| out_im | output | 16 | Scaled imaginary part |

## Verification
A stage maximum that is not cleared, or that misses one part, shows up as a wrong `shift_out` at the very next `shift_valid` pulse. Because every stage adds into the exponent, the same fault also leaves `exp_out` off by the missing amount for every later stage of the frame. A misclassified top-bit pattern shows up at the end of the stage that contains it. A shift register that updates on the wrong edge appears one cycle after the affected operand, as a scaled output with the wrong magnitude or sign.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

  typedef enum logic [1:0] {
    GROW_NONE = 2'd0,
    GROW_ONE  = 2'd1,
    GROW_TWO  = 2'd2
  } grow_e;

  localparam int unsigned GUARD_BITS = 3;

  function automatic grow_e grow_max(input grow_e a, input grow_e b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bfp_word_classifier.sv
module bfp_word_classifier
  import bfp_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic [WORD_W-1:0] word,
  output grow_e             cls
);

  localparam int unsigned TOP = WORD_W - 1;

  logic [GUARD_BITS-1:0] top_bits;

  always_comb begin
    top_bits = word[TOP -: GUARD_BITS];
    unique case (top_bits)
      3'b000, 3'b111: cls = GROW_NONE;
      3'b001, 3'b110: cls = GROW_ONE;
      default:        cls = GROW_TWO;
    endcase
  end

endmodule

// File: rtl/bfp_stage_tracker.sv
module bfp_stage_tracker
  import bfp_pkg::*;
#(
  parameter int unsigned EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             word_valid,
  input  grow_e            word_cls,
  input  logic             stage_end,
  output logic [1:0]       shift,
  output logic             shift_valid,
  output logic [EXP_W-1:0] block_exp
);

  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  grow_e            stage_max_q, stage_max_d;
  grow_e            stage_cand;
  logic [1:0]       shift_q, shift_d;
  logic             pulse_q, pulse_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [EXP_W:0]   exp_sum;
  logic             close_stage;

  always_comb begin
    stage_cand  = word_valid ? grow_max(stage_max_q, word_cls) : stage_max_q;
    close_stage = stage_end && !frame_start;
    exp_sum     = {1'b0, exp_q} + {{(EXP_W-1){1'b0}}, stage_cand};

    stage_max_d = stage_cand;
    shift_d     = shift_q;
    pulse_d     = 1'b0;
    exp_d       = exp_q;

    if (frame_start) begin
      stage_max_d = GROW_NONE;
      shift_d     = 2'd0;
      exp_d       = '0;
    end else if (close_stage) begin
      stage_max_d = GROW_NONE;
      shift_d     = stage_cand;
      pulse_d     = 1'b1;
      exp_d       = exp_sum[EXP_W] ? EXP_MAX : exp_sum[EXP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_max_q <= GROW_NONE;
      shift_q     <= 2'd0;
      pulse_q     <= 1'b0;
      exp_q       <= '0;
    end else begin
      stage_max_q <= stage_max_d;
      shift_q     <= shift_d;
      pulse_q     <= pulse_d;
      exp_q       <= exp_d;
    end
  end

  assign shift       = shift_q;
  assign shift_valid = pulse_q;
  assign block_exp   = exp_q;

endmodule

// File: rtl/bfp_lane_shifter.sv
module bfp_lane_shifter #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       shift,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  logic signed [IN_W-1:0] shifted;
  logic [OUT_W-1:0]       dout_q, dout_d;

  always_comb begin
    shifted = $signed(din) >>> shift;
    dout_d  = en ? shifted[OUT_W-1:0] : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/bfp_stage_scaler.sv
module bfp_stage_scaler
  import bfp_pkg::*;
#(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             res_valid,
  input  logic [IN_W-1:0]  res_re,
  input  logic [IN_W-1:0]  res_im,
  input  logic             stage_end,
  output logic [1:0]       shift_out,
  output logic             shift_valid,
  output logic [EXP_W-1:0] exp_out,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im
);

  localparam int unsigned LANES = 2;

  logic [1:0]            rst_sync_q;
  logic                  rst_sync_n;
  logic [IN_W-1:0]       res_word [LANES];
  logic [IN_W-1:0]       in_word  [LANES];
  logic [OUT_W-1:0]      out_word [LANES];
  grow_e                 lane_cls [LANES];
  grow_e                 word_cls;
  logic                  out_valid_q, out_valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign res_word[0] = res_re;
  assign res_word[1] = res_im;
  assign in_word[0]  = in_re;
  assign in_word[1]  = in_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bfp_word_classifier #(.WORD_W(IN_W)) u_cls (
      .word (res_word[g]),
      .cls  (lane_cls[g])
    );

    bfp_lane_shifter #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shf (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (in_valid),
      .shift (shift_out),
      .din   (in_word[g]),
      .dout  (out_word[g])
    );
  end

  assign word_cls = grow_max(lane_cls[0], lane_cls[1]);

  bfp_stage_tracker #(.EXP_W(EXP_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .word_valid  (res_valid),
    .word_cls    (word_cls),
    .stage_end   (stage_end),
    .shift       (shift_out),
    .shift_valid (shift_valid),
    .block_exp   (exp_out)
  );

  always_comb out_valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid_q <= 1'b0;
    else             out_valid_q <= out_valid_d;
  end

  assign out_valid = out_valid_q;
  assign out_re    = out_word[0];
  assign out_im    = out_word[1];

endmodule

// File: rtl/bfp_stage_scaler_chk.sv
module bfp_stage_scaler_chk #(
  parameter int unsigned EXP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             stage_end,
  input logic             in_valid,
  input logic [1:0]       shift_out,
  input logic             shift_valid,
  input logic [EXP_W-1:0] exp_out,
  input logic             out_valid
);

  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  p_shift_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_out != 2'd3);

  p_stage_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_end && !frame_start) |=> shift_valid);

  p_pulse_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_end || frame_start) |=> !shift_valid);

  p_shift_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_end && !frame_start) |=> $stable(shift_out));

  p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (exp_out == '0) && (shift_out == 2'd0));

  p_exp_accum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_end && !frame_start) |=>
      (exp_out == $past(exp_out) + {{(EXP_W-2){1'b0}}, shift_out}) ||
      (exp_out == EXP_MAX && exp_out >= $past(exp_out)));

  p_exp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_end && !frame_start) |=> $stable(exp_out));

  p_out_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

bind bfp_stage_scaler bfp_stage_scaler_chk #(.EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .frame_start (frame_start),
  .stage_end   (stage_end),
  .in_valid    (in_valid),
  .shift_out   (shift_out),
  .shift_valid (shift_valid),
  .exp_out     (exp_out),
  .out_valid   (out_valid)
);

// File: tb/bfp_stage_scaler_tb.sv
module bfp_stage_scaler_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  IN_W  = 18;
  localparam int  OUT_W = 16;
  localparam int  EXP_W = 5;

  typedef struct {
    logic [1:0]       shift;
    logic [EXP_W-1:0] expo;
    string            tag;
  } stage_item_t;

  typedef struct {
    logic [OUT_W-1:0] re;
    logic [OUT_W-1:0] im;
  } data_item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             frame_start, res_valid, stage_end, in_valid;
  logic [IN_W-1:0]  res_re, res_im, in_re, in_im;
  logic [1:0]       shift_out;
  logic             shift_valid, out_valid;
  logic [EXP_W-1:0] exp_out;
  logic [OUT_W-1:0] out_re, out_im;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  stage_item_t stage_q[$];
  data_item_t  data_q[$];

  int               m_max;
  logic [1:0]       m_shift;
  logic [EXP_W-1:0] m_exp;
  string            cur_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfp_stage_scaler #(.IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .res_valid(res_valid), .res_re(res_re), .res_im(res_im),
    .stage_end(stage_end), .shift_out(shift_out), .shift_valid(shift_valid),
    .exp_out(exp_out), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int cls_of(input logic [IN_W-1:0] w);
    case (w[IN_W-1 -: 3])
      3'b000, 3'b111: return 0;
      3'b001, 3'b110: return 1;
      default:        return 2;
    endcase
  endfunction

  function automatic logic [IN_W-1:0] mk(input logic [2:0] top, input logic [14:0] low);
    return {top, low};
  endfunction

  function automatic logic [OUT_W-1:0] scale(input logic [IN_W-1:0] w, input logic [1:0] s);
    logic signed [IN_W-1:0] t;
    t = $signed(w) >>> s;
    return t[OUT_W-1:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // one cycle of stimulus; the model is updated in the order the design sees it
  task automatic drive(input logic v, input logic [IN_W-1:0] re, input logic [IN_W-1:0] im,
                       input logic se, input logic fs);
    int sh;
    int sum;
    stage_item_t it;
    data_item_t  d;
    @(negedge clk);
    res_valid = v; res_re = re; res_im = im;
    in_valid = v;  in_re = re;  in_im = im;
    stage_end = se; frame_start = fs;
    if (v) begin
      d.re = scale(re, m_shift);
      d.im = scale(im, m_shift);
      data_q.push_back(d);
      if (cls_of(re) > m_max) m_max = cls_of(re);
      if (cls_of(im) > m_max) m_max = cls_of(im);
    end
    if (fs) begin
      m_max = 0; m_shift = 2'd0; m_exp = '0;
    end else if (se) begin
      sh  = m_max;
      sum = int'(m_exp) + sh;
      if (sum > (1 << EXP_W) - 1) sum = (1 << EXP_W) - 1;
      m_exp   = sum[EXP_W-1:0];
      m_shift = sh[1:0];
      it.shift = m_shift; it.expo = m_exp; it.tag = cur_tag;
      stage_q.push_back(it);
      m_max = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && shift_valid) begin
        if (stage_q.size() == 0) begin
          check("R7 unexpected shift_valid", 32'd1, 32'd0);
        end else begin
          stage_item_t it;
          it = stage_q.pop_front();
          check({it.tag, " shift"}, 32'(shift_out), 32'(it.shift));
          check({it.tag, " R6 exponent"}, 32'(exp_out), 32'(it.expo));
        end
      end
      if (rst_n && out_valid) begin
        if (data_q.size() == 0) begin
          check("R8 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          data_item_t d;
          d = data_q.pop_front();
          check("R8 out_re", 32'(out_re), 32'(d.re));
          check("R8 out_im", 32'(out_im), 32'(d.im));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    frame_start = 0; res_valid = 0; stage_end = 0; in_valid = 0;
    res_re = '0; res_im = '0; in_re = '0; in_im = '0;
    m_max = 0; m_shift = 2'd0; m_exp = '0; cur_tag = "R9";
    repeat (3) @(negedge clk);
    check("R9 shift_out", 32'(shift_out), 32'd0);
    check("R9 exp_out", 32'(exp_out), 32'd0);
    check("R9 shift_valid", 32'(shift_valid), 32'd0);
    check("R9 out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    idle(4);

    drive(1'b0, '0, '0, 1'b0, 1'b1);
    // stage 1: class 0 words only, class 2 shown with valid low (R1, R4)
    cur_tag = "R1 R4 stage1";
    drive(1'b1, mk(3'b000, 15'h1234), mk(3'b111, 15'h7abc), 1'b0, 1'b0);
    drive(1'b0, mk(3'b010, 15'h0), mk(3'b101, 15'h0), 1'b0, 1'b0);
    drive(1'b1, mk(3'b111, 15'h0001), mk(3'b000, 15'h7fff), 1'b1, 1'b0);
    // stage 2: class 1 in imaginary part only (R2)
    cur_tag = "R2 stage2";
    drive(1'b1, mk(3'b000, 15'h0f0f), mk(3'b001, 15'h2222), 1'b0, 1'b0);
    drive(1'b1, mk(3'b111, 15'h3333), mk(3'b000, 15'h0), 1'b1, 1'b0);
    // stage 3: pattern 010 (R3)
    cur_tag = "R3 stage3";
    drive(1'b1, mk(3'b010, 15'h1111), mk(3'b000, 15'h0), 1'b0, 1'b0);
    drive(1'b1, mk(3'b110, 15'h5555), mk(3'b111, 15'h0), 1'b1, 1'b0);
    // stage 4: pattern 100 in imaginary part (R3)
    cur_tag = "R3 stage4";
    drive(1'b1, mk(3'b000, 15'h0), mk(3'b100, 15'h0abc), 1'b1, 1'b0);
    // stage 5: 110 mixed with class 0, max must be 1 after a class-2 stage (R2, R5)
    cur_tag = "R2 R5 stage5";
    drive(1'b1, mk(3'b110, 15'h0100), mk(3'b000, 15'h0), 1'b0, 1'b0);
    drive(1'b1, mk(3'b000, 15'h0), mk(3'b111, 15'h7000), 1'b1, 1'b0);
    // stage 6: no valid words at all (R4, R5)
    cur_tag = "R4 R5 stage6";
    idle(2);
    drive(1'b0, '0, '0, 1'b1, 1'b0);
    // stage 7: class 2 arrives in the stage_end cycle (R5)
    cur_tag = "R5 stage7";
    drive(1'b1, mk(3'b000, 15'h0), mk(3'b000, 15'h0), 1'b0, 1'b0);
    drive(1'b1, mk(3'b011, 15'h6666), mk(3'b000, 15'h0), 1'b1, 1'b0);
    // stage 8: 101 (R3)
    cur_tag = "R3 stage8";
    drive(1'b1, mk(3'b101, 15'h0aaa), mk(3'b001, 15'h0), 1'b1, 1'b0);
    // stage 9: 001 in real part (R2)
    cur_tag = "R2 R6 stage9";
    drive(1'b1, mk(3'b001, 15'h0001), mk(3'b111, 15'h0), 1'b1, 1'b0);
    idle(3);
    check("R6 exponent after nine stages", 32'(exp_out), 32'd11);

    // frame start clears; stage_end in the same cycle is ignored (R7)
    drive(1'b1, mk(3'b010, 15'h0), mk(3'b010, 15'h0), 1'b1, 1'b1);
    idle(3);
    check("R7 exp_out after frame_start", 32'(exp_out), 32'd0);
    check("R7 shift_out after frame_start", 32'(shift_out), 32'd0);
    cur_tag = "R7 stage after clear";
    drive(1'b1, mk(3'b000, 15'h0), mk(3'b111, 15'h0), 1'b1, 1'b0);

    // saturation of the exponent (R6)
    cur_tag = "R6 saturate";
    for (int i = 0; i < 17; i++) drive(1'b1, mk(3'b100, 15'(i)), mk(3'b011, 15'h0), 1'b1, 1'b0);
    idle(3);
    check("R6 saturated exponent", 32'(exp_out), 32'd31);
    check("R5 queue drained", 32'(stage_q.size()), 32'd0);
    check("R8 queue drained", 32'(data_q.size()), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule